// File: doc/BRIEF.md
# Fatal/Non-Fatal Interrupt Arbiter

This block gathers interrupt events for a storage bus controller. It has two source groups. The bus-side group has sixteen events and the DMA-side group has eight. A single interrupt-on-the-fly event is handled apart from both groups. Each event is latched into a status bit, and the host clears it by writing a one. Each group has its own enable bits.

From the status bits, the enable bits and the current operating mode (initiator or target), the block decides whether each event is fatal or non-fatal. It then drives four outputs:

- a halt request to the instruction sequencer,
- a summary pending flag for each group,
- an active-low, level-sensitive interrupt pin.

Enabling a non-fatal source promotes it to fatal. A masked fatal source still halts the sequencer but leaves the pin alone. A masked non-fatal source only records its status bit. A global pin-mask bit holds the pin high and loses no pending state. The host reaches all of this through a small register port with an 8-bit data path and a 3-bit address.

Top module: `intarb_top`

## Requirements
- R1: After reset, all status, enable and control bits are zero, haltReq, busPend and dmaPend are low, and intN is high.
- R2: An event pulse sets its status bit on the clock edge where it is sampled. A register write of ones clears the matching status bits. Status is at address 0 (bus events 7..0), address 1 (bus events 15..8) and address 2 (DMA events). If an event and a clear hit the same bit in the same cycle, the bit stays set.
- R3: Every DMA event is fatal. It raises haltReq on the next edge and sets dmaPend, whatever its enable bit (address 5) says.
- R4: In initiator mode (targetMode=0), bus events 0, 1, 2, 8 and 9 are non-fatal. All other bus events are fatal.
- R5: In target mode (targetMode=1), bus event 3 is also non-fatal. Because the classification is combinational, a latched event 3 changes busPend when the mode changes.
- R6: When a bus event's enable bit is set (address 3 for events 7..0, address 4 for 15..8), the event is fatal in either mode. It raises haltReq and busPend, and it drives intN.
- R7: A masked non-fatal bus event sets only its status bit. busPend, haltReq and intN stay unchanged.
- R8: A masked fatal event raises haltReq and its group summary flag, but does not drive intN.
- R9: The interrupt-on-the-fly event sets a flag that is read at address 7 bit 2 and cleared by writing a one to that bit. The flag drives intN and never raises haltReq.
- R10: While the pin-mask bit (address 6 bit 0) is set, intN stays high. Clearing the bit while a drive source is pending pulls intN low on the following edge.
- R11: intN is registered. It goes low on the edge after an enabled pending status bit or the fly flag exists while the pin-mask bit is clear, and it returns high one edge after those conditions end.
- R12: haltReq stays high until restart is sampled high while busPend and dmaPend are both low. A restart that arrives while either flag is set is ignored. A fatal event arriving in the same cycle as a restart keeps haltReq high.
- R13: Address 7 reads {4'b0, haltReq, fly flag, dmaPend, busPend}. Enable and control registers read back as written, and status registers read as latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| targetMode | input | 1 | 1 = target mode, 0 = initiator mode |
| busEvt | input | 16 | Bus-side event pulses |
| dmaEvt | input | 8 | DMA-side event pulses |
| flyEvt | input | 1 | Interrupt-on-the-fly event pulse |
| restart | input | 1 | Sequencer restart pulse from the host |
| regAddr | input | 3 | Register address |
| regWr | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data (combinational on regAddr) |
| haltReq | output | 1 | Halt request to the instruction sequencer |
| busPend | output | 1 | Bus group summary pending flag |
| dmaPend | output | 1 | DMA group summary pending flag |
| intN | output | 1 | Active-low interrupt pin |

## Verification
Two kinds of collision are provoked on purpose. In the first, a new event lands on a status bit in the same cycle as the host's write-one-to-clear of that bit. In the second, a fatal arrival coincides with a restart pulse. The bench drives both pairs on one edge in directed steps, then repeats them many times in a long pseudo-random phase. In that phase, event pulses, register writes, restarts and mode flips overlap freely. A behavioural reference model resolves each collision as the requirements state: the set wins over the clear, and the arrival wins over the restart. Every output and the read port are compared against this model after every edge.

// File: rtl/intarb_pkg.sv
package intarb_pkg;
  localparam int REG_W     = 8;
  localparam int BUS_BYTES = 2;
  localparam int BUS_W     = REG_W * BUS_BYTES;
  localparam int DMA_W     = REG_W;
  localparam int ADDR_W    = 3;

  // bus events that are non-fatal while masked
  localparam logic [BUS_W-1:0] NF_INITIATOR  = 16'h0307;
  localparam logic [BUS_W-1:0] NF_TARGET_ADD = 16'h0008;

  localparam logic [ADDR_W-1:0] A_BSTAT0 = 3'd0;
  localparam logic [ADDR_W-1:0] A_DSTAT  = 3'd2;
  localparam logic [ADDR_W-1:0] A_BEN0   = 3'd3;
  localparam logic [ADDR_W-1:0] A_DEN    = 3'd5;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd6;
  localparam logic [ADDR_W-1:0] A_SUM    = 3'd7;
  localparam int SUM_FLY_BIT = 2;

  typedef struct packed {
    logic [BUS_BYTES-1:0] clrBus;
    logic                 clrDma;
    logic                 clrFly;
    logic [BUS_BYTES-1:0] wrBusEn;
    logic                 wrDmaEn;
    logic                 wrCtrl;
    logic [REG_W-1:0]     data;
  } regStrobe_t;
endpackage

// File: rtl/intarb_ctrl.sv
module intarb_ctrl
  import intarb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              restart,
  input  logic              fatalArrive,
  input  logic              anyPend,
  input  logic              pinDrive,
  input  logic              pinMask,
  output regStrobe_t        strb,
  output logic              haltReq,
  output logic              intN
);
  // address decode into one-cycle strobes
  genvar b;
  generate
    for (b = 0; b < BUS_BYTES; b++) begin : g_dec
      assign strb.clrBus[b]  = regWr && (regAddr == A_BSTAT0 + ADDR_W'(b));
      assign strb.wrBusEn[b] = regWr && (regAddr == A_BEN0 + ADDR_W'(b));
    end
  endgenerate

  assign strb.clrDma  = regWr && (regAddr == A_DSTAT);
  assign strb.clrFly  = regWr && (regAddr == A_SUM) && regWrData[SUM_FLY_BIT];
  assign strb.wrDmaEn = regWr && (regAddr == A_DEN);
  assign strb.wrCtrl  = regWr && (regAddr == A_CTRL);
  assign strb.data    = regWrData;

  // halt latch: a new fatal arrival outranks a restart
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                     haltReq <= 1'b0;
    else if (fatalArrive)          haltReq <= 1'b1;
    else if (restart && !anyPend)  haltReq <= 1'b0;
  end

  // registered level pin, active low
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intN <= 1'b1;
    else       intN <= !(pinDrive && !pinMask);
  end
endmodule

// File: rtl/intarb_dp.sv
module intarb_dp
  import intarb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              targetMode,
  input  logic [BUS_W-1:0]  busEvt,
  input  logic [DMA_W-1:0]  dmaEvt,
  input  logic              flyEvt,
  input  regStrobe_t        strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              haltReq,
  output logic [REG_W-1:0]  regRdData,
  output logic              busPend,
  output logic              dmaPend,
  output logic              fatalArrive,
  output logic              pinDrive,
  output logic              pinMask,
  output logic              flyQ
);
  logic [BUS_W-1:0] busStat, busEn, nfMask, fatalSel;
  logic [DMA_W-1:0] dmaStat, dmaEn;

  genvar b;
  generate
    for (b = 0; b < BUS_BYTES; b++) begin : g_lane
      logic [REG_W-1:0] statQ, enQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          statQ <= '0;
          enQ   <= '0;
        end else begin
          statQ <= (statQ & ~(strb.clrBus[b] ? strb.data : '0))
                   | busEvt[b*REG_W +: REG_W];
          if (strb.wrBusEn[b]) enQ <= strb.data;
        end
      end
      assign busStat[b*REG_W +: REG_W] = statQ;
      assign busEn[b*REG_W +: REG_W]   = enQ;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaStat <= '0;
      dmaEn   <= '0;
      pinMask <= 1'b0;
      flyQ    <= 1'b0;
    end else begin
      dmaStat <= (dmaStat & ~(strb.clrDma ? strb.data : '0)) | dmaEvt;
      if (strb.wrDmaEn) dmaEn   <= strb.data;
      if (strb.wrCtrl)  pinMask <= strb.data[0];
      flyQ <= (flyQ && !strb.clrFly) || flyEvt;
    end
  end

  // fatal classification: enabled, or outside the mode's non-fatal set
  assign nfMask      = NF_INITIATOR | (targetMode ? NF_TARGET_ADD : '0);
  assign fatalSel    = busEn | ~nfMask;
  assign busPend     = |(busStat & fatalSel);
  assign dmaPend     = |dmaStat;
  assign fatalArrive = (|(busEvt & fatalSel)) || (|dmaEvt);
  assign pinDrive    = (|(busStat & busEn)) || (|(dmaStat & dmaEn)) || flyQ;

  always_comb begin
    case (regAddr)
      3'd0:    regRdData = busStat[REG_W-1:0];
      3'd1:    regRdData = busStat[BUS_W-1:REG_W];
      3'd2:    regRdData = dmaStat;
      3'd3:    regRdData = busEn[REG_W-1:0];
      3'd4:    regRdData = busEn[BUS_W-1:REG_W];
      3'd5:    regRdData = dmaEn;
      3'd6:    regRdData = {{(REG_W-1){1'b0}}, pinMask};
      default: regRdData = {{(REG_W-4){1'b0}}, haltReq, flyQ, dmaPend, busPend};
    endcase
  end
endmodule

// File: rtl/intarb_top.sv
module intarb_top
  import intarb_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              targetMode,
  input  logic [BUS_W-1:0]  busEvt,
  input  logic [DMA_W-1:0]  dmaEvt,
  input  logic              flyEvt,
  input  logic              restart,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  regRdData,
  output logic              haltReq,
  output logic              busPend,
  output logic              dmaPend,
  output logic              intN
);
  regStrobe_t strbW;
  logic fatalArriveW, pinDriveW, pinMaskW, flyQW;

  intarb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr),
    .regWrData(regWrData), .restart(restart), .fatalArrive(fatalArriveW),
    .anyPend(busPend || dmaPend), .pinDrive(pinDriveW), .pinMask(pinMaskW),
    .strb(strbW), .haltReq(haltReq), .intN(intN)
  );

  intarb_dp i_dp (
    .clk(clk), .rstN(rstN), .targetMode(targetMode), .busEvt(busEvt),
    .dmaEvt(dmaEvt), .flyEvt(flyEvt), .strb(strbW), .regAddr(regAddr),
    .haltReq(haltReq), .regRdData(regRdData), .busPend(busPend),
    .dmaPend(dmaPend), .fatalArrive(fatalArriveW), .pinDrive(pinDriveW),
    .pinMask(pinMaskW), .flyQ(flyQW)
  );
endmodule

// File: rtl/intarb_chk.sv
module intarb_chk
  import intarb_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [BUS_W-1:0] busEvt,
  input logic [DMA_W-1:0] dmaEvt,
  input logic             restart,
  input logic             haltReq,
  input logic             busPend,
  input logic             dmaPend,
  input logic             intN,
  input logic             pinMask,
  input logic             flyQ
);
  assert_dma_halt_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|dmaEvt) |=> haltReq);

  assert_dma_pend_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|dmaEvt) |=> dmaPend);

  assert_halt_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq && !restart) |=> haltReq);

  assert_restart_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    (haltReq && (busPend || dmaPend)) |=> haltReq);

  assert_pin_mask_R10: assert property (@(posedge clk) disable iff (!rstN)
    pinMask |=> intN);

  assert_pin_source_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!intN && !$rose(rstN)) |-> $past(busPend || dmaPend || flyQ));

  assert_no_spurious_halt_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!haltReq && !(|busEvt) && !(|dmaEvt)) |=> !haltReq);
endmodule

bind intarb_top intarb_chk i_chk (
  .clk(clk), .rstN(rstN), .busEvt(busEvt), .dmaEvt(dmaEvt),
  .restart(restart), .haltReq(haltReq), .busPend(busPend),
  .dmaPend(dmaPend), .intN(intN), .pinMask(pinMaskW), .flyQ(flyQW)
);

// File: tb/test_intarb_top.sv
module test_intarb_top;
  localparam int CYC = 8;

  logic clk = 1'b0;
  always #(CYC/2) clk = ~clk;

  logic        rstN, targetMode, flyEvt, restart, regWr;
  logic [15:0] busEvt;
  logic [7:0]  dmaEvt, regWrData, regRdData;
  logic [2:0]  regAddr;
  logic        haltReq, busPend, dmaPend, intN;

  intarb_top i_intarb_top (
    .clk(clk), .rstN(rstN), .targetMode(targetMode), .busEvt(busEvt),
    .dmaEvt(dmaEvt), .flyEvt(flyEvt), .restart(restart), .regAddr(regAddr),
    .regWr(regWr), .regWrData(regWrData), .regRdData(regRdData),
    .haltReq(haltReq), .busPend(busPend), .dmaPend(dmaPend), .intN(intN)
  );

  int    checks = 0, fails = 0;
  bit    done = 0;
  string curReq = "R1";

  // ---------------- reference model ----------------
  logic [15:0] mBus, mBusEn;
  logic [7:0]  mDma, mDmaEn;
  logic        mMask, mFly, mHalt, mPin;

  function automatic bit isNonFatal(int i, logic tgt);
    return (i == 0 || i == 1 || i == 2 || i == 8 || i == 9 || (tgt && i == 3));
  endfunction

  function automatic logic modelBusPend();
    for (int i = 0; i < 16; i++)
      if (mBus[i] && (mBusEn[i] || !isNonFatal(i, targetMode))) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] modelRead(logic [2:0] a);
    case (a)
      3'd0: return mBus[7:0];
      3'd1: return mBus[15:8];
      3'd2: return mDma;
      3'd3: return mBusEn[7:0];
      3'd4: return mBusEn[15:8];
      3'd5: return mDmaEn;
      3'd6: return {7'b0, mMask};
      default: return {4'b0, mHalt, mFly, (mDma != 0), modelBusPend()};
    endcase
  endfunction

  task automatic chk(string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mBus = 0; mBusEn = 0; mDma = 0; mDmaEn = 0;
      mMask = 0; mFly = 0; mHalt = 0; mPin = 1;
    end else begin
      logic drive, fatalArr, anyPend;
      drive = mFly;
      fatalArr = (dmaEvt != 0);
      for (int i = 0; i < 16; i++) begin
        if (mBus[i] && mBusEn[i]) drive = 1;
        if (busEvt[i] && (mBusEn[i] || !isNonFatal(i, targetMode))) fatalArr = 1;
      end
      for (int i = 0; i < 8; i++) if (mDma[i] && mDmaEn[i]) drive = 1;
      anyPend = modelBusPend() || (mDma != 0);
      if (fatalArr) mHalt = 1;
      else if (restart && !anyPend) mHalt = 0;
      mPin = !(drive && !mMask);
      if (regWr && regAddr == 3'd0) mBus[7:0]  = mBus[7:0]  & ~regWrData;
      if (regWr && regAddr == 3'd1) mBus[15:8] = mBus[15:8] & ~regWrData;
      if (regWr && regAddr == 3'd2) mDma = mDma & ~regWrData;
      if (regWr && regAddr == 3'd7 && regWrData[2]) mFly = 0;
      if (regWr && regAddr == 3'd3) mBusEn[7:0]  = regWrData;
      if (regWr && regAddr == 3'd4) mBusEn[15:8] = regWrData;
      if (regWr && regAddr == 3'd5) mDmaEn = regWrData;
      if (regWr && regAddr == 3'd6) mMask = regWrData[0];
      mBus = mBus | busEvt;
      mDma = mDma | dmaEvt;
      if (flyEvt) mFly = 1;
    end
    #2;
    chk("haltReq",   {7'b0, haltReq}, {7'b0, mHalt});
    chk("busPend",   {7'b0, busPend}, {7'b0, modelBusPend()});
    chk("dmaPend",   {7'b0, dmaPend}, {7'b0, (mDma != 0)});
    chk("intN",      {7'b0, intN},    {7'b0, mPin});
    chk("regRdData", regRdData, modelRead(regAddr));
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    regAddr = a; regWrData = d; regWr = 1; tick(); regWr = 0;
  endtask

  task automatic busPulse(logic [15:0] v);
    busEvt = v; tick(); busEvt = 0;
  endtask

  task automatic dmaPulse(logic [7:0] v);
    dmaEvt = v; tick(); dmaEvt = 0;
  endtask

  task automatic pulseRestart();
    restart = 1; tick(); restart = 0;
  endtask

  initial begin
    rstN = 0; targetMode = 0; flyEvt = 0; restart = 0; regWr = 0;
    busEvt = 0; dmaEvt = 0; regWrData = 0; regAddr = 3'd7;
    curReq = "R1"; tick(3);
    rstN = 1; tick(2);

    curReq = "R7"; regAddr = 3'd0;          // masked non-fatal, initiator
    busPulse(16'h0001); tick(2);
    busPulse(16'h0100); regAddr = 3'd1; tick(2);
    curReq = "R2"; wr(3'd1, 8'h01); wr(3'd0, 8'h01); tick(2);

    curReq = "R8"; regAddr = 3'd7;          // masked fatal bus event 4
    busPulse(16'h0010); tick(2);
    curReq = "R12"; pulseRestart(); tick(2); // ignored while pending
    wr(3'd0, 8'h10); pulseRestart(); tick(2);

    curReq = "R6"; wr(3'd3, 8'h02);          // enable event 1
    busPulse(16'h0002); tick(3);
    curReq = "R10"; wr(3'd6, 8'h01); tick(3);
    wr(3'd6, 8'h00); tick(2);
    curReq = "R11"; wr(3'd0, 8'h02); tick(2);
    curReq = "R12"; pulseRestart(); tick(2);

    curReq = "R5"; targetMode = 1;          // event 3 non-fatal in target
    busPulse(16'h0008); tick(2);
    curReq = "R4"; targetMode = 0; tick(2); // same bit now fatal
    wr(3'd0, 8'h08); pulseRestart(); tick(2);
    busPulse(16'h1000); tick(2);            // bus 12 fatal in initiator
    wr(3'd1, 8'h10); pulseRestart(); tick(2);

    curReq = "R3"; regAddr = 3'd2;          // DMA fatal even if masked
    dmaPulse(8'h04); tick(2);
    wr(3'd5, 8'h04); tick(2);
    wr(3'd2, 8'h04); pulseRestart(); tick(2);

    curReq = "R9"; regAddr = 3'd7;
    flyEvt = 1; tick(); flyEvt = 0; tick(3);
    wr(3'd7, 8'h04); tick(2);

    curReq = "R2"; regAddr = 3'd0;          // set and clear collide
    busPulse(16'h0020); tick();
    busEvt = 16'h0020; regWrData = 8'h20; regWr = 1; tick();
    busEvt = 0; regWr = 0; tick(2);
    wr(3'd0, 8'h20);
    curReq = "R12"; dmaPulse(8'h01); wr(3'd2, 8'h01);
    dmaEvt = 8'h02; restart = 1; tick();    // arrival beats restart
    dmaEvt = 0; restart = 0; tick(2);
    wr(3'd2, 8'hFF); pulseRestart(); tick(2);

    curReq = "R13";
    for (int a = 0; a < 8; a++) begin regAddr = 3'(a); tick(); end

    curReq = "mixed";
    for (int n = 0; n < 4000; n++) begin
      busEvt  = ($urandom % 6 == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
      dmaEvt  = ($urandom % 20 == 0) ? 8'(1 << ($urandom % 8)) : 8'h0;
      flyEvt  = ($urandom % 25 == 0);
      restart = ($urandom % 5 == 0);
      regWr   = ($urandom % 3 == 0);
      regAddr = 3'($urandom % 8);
      regWrData = 8'($urandom);
      if ($urandom % 50 == 0) targetMode = ~targetMode;
      tick();
    end
    busEvt = 0; dmaEvt = 0; flyEvt = 0; restart = 0; regWr = 0;
    tick(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CYC * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule